// File: doc/BRIEF.md
# Serial PSRAM identification sequencer

This block is a small hardware sequencer that runs once per request, typically at power-up, to find out whether a serial PSRAM sits on its chip select and how large it is. It drives the memory's pins directly: a serial clock, an active-low chip select, and four data lines that each have their own output enable. The serial clock is the system clock divided by a parameter, 30 by default.

A probe starts with a request pulse. The sequencer first waits until any earlier transfer on the memory pins has finished. It then sends one byte on all four data lines, which returns a device that may have been left in quad mode to single-line mode. After a short deselect gap it opens one chip-select frame of seven single-line byte transfers: a read-ID command followed by six filler bytes. Two of the returned bytes, the die-status byte and the extended-ID byte, are decoded into a present flag and a capacity in bytes. When that is finished the sequencer releases the chip select and pulses done. The result then stays on the outputs until the next request.

Top module: `psram_probe_seq`

## Requirements
- R1: While reset is high and after its release, `csn_o` is 1, `sck_o` is 0, `sd_oe_o` is 0000, `done_o` is 0, `detected_o` is 0 and `size_o` is 0.
- R2: A request accepted while `busy_i` is 1 does not lower `csn_o` until `busy_i` has been seen at 0.
- R3: The first frame drives `sd_oe_o`=1111 and carries byte 0xF5 in two serial clocks on `sd_o[3:0]`, upper nibble first. `csn_o` then stays high for exactly GAP_CYCLES system clocks before the ID frame begins.
- R4: The ID frame is a single low period of `csn_o` with `sd_oe_o`=0001. In it, 56 bits are sent MSB first on `sd_o[0]`: 0x9F followed by six bytes of 0xFF.
- R5: The serial clock idles low (mode 0). `sd_i[1]` is sampled on the rising serial clock edge, and `sd_o` changes only away from rising edges.
- R6: Received bytes are numbered 0 to 6 in the order they arrive. Byte 5 is the die-status byte and byte 6 is the extended-ID byte. `detected_o` becomes 1 only when the die-status byte is 0x5D. Otherwise `size_o` is 0, and `size_o` is 0 whenever `detected_o` is 0.
- R7: For a good die, `size_o` is decided in this priority order:
  - An extended ID of exactly 0x26 gives 8 MiB (0x800000).
  - Otherwise, extended-ID bits [7:5] equal to 2 give 8 MiB.
  - Bits [7:5] equal to 0 give 2 MiB.
  - Bits [7:5] equal to 1 give 4 MiB.
  - Any other value gives 1 MiB.
- R8: The serial clock period is DIV system clocks (30 by default), with equal high and low halves.
- R9: `csn_o` goes high in the same cycle that `done_o` pulses for exactly one cycle with the new result. The result then holds until the next request, and accepting a request clears `detected_o` and `size_o` to 0.
- R10: A request that arrives while a probe is running is ignored, so no second probe follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Probe request pulse |
| busy_i | input | 1 | Earlier transfer or cooldown still in progress on the memory pins |
| sck_o | output | 1 | Serial clock to the memory |
| csn_o | output | 1 | Active-low chip select |
| sd_o | output | 4 | Data driven toward the memory; line 0 is the single-line output |
| sd_oe_o | output | 4 | Output enable for each data line |
| sd_i | input | 4 | Data from the memory; line 1 is the single-line input |
| done_o | output | 1 | One-cycle pulse when a probe finishes |
| detected_o | output | 1 | A good die was found |
| size_o | output | 24 | Capacity in bytes, 0 when nothing was found |

## Verification
The assertions assume three things about the inputs:
- `start_i` is a single-cycle pulse.
- `busy_i` eventually falls.
- `sd_i` changes only while the serial clock is low, well before the next rising edge.

The bench's memory model keeps to these by updating its input line only halfway between system clock edges, after it has seen a falling serial clock. It also releases `busy_i` after a bounded wait. Under these conditions the checks on pulse width, result stability and frame shape relate outputs and `busy_i` across cycles and need no knowledge of the device's replies.

// File: rtl/psram_probe_pkg.sv
package psram_probe_pkg;

    localparam int SIZE_W = 24;

    localparam logic [7:0] CMD_QUAD_EXIT = 8'hF5;
    localparam logic [7:0] CMD_READ_ID   = 8'h9F;
    localparam logic [7:0] CMD_FILL      = 8'hFF;
    localparam logic [7:0] DIE_PASS      = 8'h5D;
    localparam logic [7:0] EID_LARGE     = 8'h26;

    localparam int ID_XFERS = 7;
    localparam int DIE_POS  = 5;
    localparam int EID_POS  = 6;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_WAIT,
        PS_QUAD,
        PS_GAP,
        PS_ID
    } probe_state_e;

    typedef struct packed {
        logic              present;
        logic [SIZE_W-1:0] bytes;
    } probe_result_t;

    function automatic logic [SIZE_W-1:0] mib(input int n);
        return SIZE_W'(n) << 20;
    endfunction

endpackage

// File: rtl/probe_tick_gen.sv
module probe_tick_gen #(
    parameter int DIV = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/probe_byte_shifter.sv
module probe_byte_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       quad,
    input  logic [7:0] tx_byte,
    input  logic [3:0] sd_i,
    input  logic       tick,
    output logic       active_o,
    output logic       sck_o,
    output logic [3:0] sd_o,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    logic       active;
    logic       sck;
    logic       quad_q;
    logic [7:0] tx_sh;
    logic [7:0] rx_sh;
    logic [2:0] cnt;
    logic [2:0] last;

    assign last = quad_q ? 3'd1 : 3'd7;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sck    <= 1'b0;
            quad_q <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            cnt    <= '0;
        end else if (go) begin
            active <= 1'b1;
            sck    <= 1'b0;
            quad_q <= quad;
            tx_sh  <= tx_byte;
            cnt    <= '0;
        end else if (active && tick) begin
            if (!sck) begin
                sck   <= 1'b1;
                rx_sh <= quad_q ? {rx_sh[3:0], sd_i} : {rx_sh[6:0], sd_i[1]};
            end else begin
                sck <= 1'b0;
                if (cnt == last) begin
                    active <= 1'b0;
                end else begin
                    cnt   <= cnt + 1'b1;
                    tx_sh <= quad_q ? {tx_sh[3:0], 4'h0} : {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assign active_o  = active;
    assign sck_o     = sck;
    assign sd_o      = quad_q ? tx_sh[7:4] : {3'b000, tx_sh[7]};
    assign rx_byte   = rx_sh;
    assign byte_done = active && tick && sck && (cnt == last);

    // R5
    sck_active_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_o) |-> $past(active));

endmodule

// File: rtl/probe_id_decode.sv
module probe_id_decode
    import psram_probe_pkg::*;
(
    input  logic [7:0]    die_byte,
    input  logic [7:0]    eid_byte,
    output probe_result_t result
);
    logic [2:0] density;

    assign density = eid_byte[7:5];

    always_comb begin
        result = '0;
        if (die_byte == DIE_PASS) begin
            result.present = 1'b1;
            if (eid_byte == EID_LARGE || density == 3'd2) begin
                result.bytes = mib(8);
            end else if (density == 3'd0) begin
                result.bytes = mib(2);
            end else if (density == 3'd1) begin
                result.bytes = mib(4);
            end else begin
                result.bytes = mib(1);
            end
        end
    end

endmodule

// File: rtl/psram_probe_seq.sv
module psram_probe_seq
    import psram_probe_pkg::*;
#(
    parameter int DIV        = 30,
    parameter int GAP_CYCLES = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              busy_i,
    output logic              sck_o,
    output logic              csn_o,
    output logic [3:0]        sd_o,
    output logic [3:0]        sd_oe_o,
    input  logic [3:0]        sd_i,
    output logic              done_o,
    output logic              detected_o,
    output logic [SIZE_W-1:0] size_o
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);
    localparam logic [2:0]    IDX_DIE  = 3'(DIE_POS);
    localparam logic [2:0]    IDX_EID  = 3'(EID_POS);

    probe_state_e  state;
    logic          csn_q;
    logic [3:0]    oe_q;
    logic          go_q;
    logic          quad_q;
    logic [7:0]    tx_q;
    logic [2:0]    idx;
    logic [GW-1:0] gap_cnt;
    logic [7:0]    die_q;
    logic          done_q;
    probe_result_t res_q;
    probe_result_t res_dec;

    logic       tick;
    logic       sh_active;
    logic [7:0] rx_byte;
    logic       byte_done;

    probe_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (go_q),
        .run   (sh_active),
        .tick  (tick)
    );

    probe_byte_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .go        (go_q),
        .quad      (quad_q),
        .tx_byte   (tx_q),
        .sd_i      (sd_i),
        .tick      (tick),
        .active_o  (sh_active),
        .sck_o     (sck_o),
        .sd_o      (sd_o),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    probe_id_decode u_dec (
        .die_byte (die_q),
        .eid_byte (rx_byte),
        .result   (res_dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_IDLE;
            csn_q   <= 1'b1;
            oe_q    <= 4'h0;
            go_q    <= 1'b0;
            quad_q  <= 1'b0;
            tx_q    <= '0;
            idx     <= '0;
            gap_cnt <= '0;
            die_q   <= '0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (state)
                PS_IDLE: begin
                    if (start_i) begin
                        res_q <= '0;
                        state <= PS_WAIT;
                    end
                end
                PS_WAIT: begin
                    if (!busy_i) begin
                        csn_q  <= 1'b0;
                        oe_q   <= 4'hF;
                        go_q   <= 1'b1;
                        quad_q <= 1'b1;
                        tx_q   <= CMD_QUAD_EXIT;
                        state  <= PS_QUAD;
                    end
                end
                PS_QUAD: begin
                    if (byte_done) begin
                        csn_q   <= 1'b1;
                        oe_q    <= 4'h0;
                        gap_cnt <= '0;
                        state   <= PS_GAP;
                    end
                end
                PS_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        csn_q  <= 1'b0;
                        oe_q   <= 4'h1;
                        go_q   <= 1'b1;
                        quad_q <= 1'b0;
                        tx_q   <= CMD_READ_ID;
                        idx    <= '0;
                        state  <= PS_ID;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                PS_ID: begin
                    if (byte_done) begin
                        if (idx == IDX_DIE) begin
                            die_q <= rx_byte;
                        end
                        if (idx == IDX_EID) begin
                            csn_q  <= 1'b1;
                            oe_q   <= 4'h0;
                            done_q <= 1'b1;
                            res_q  <= res_dec;
                            state  <= PS_IDLE;
                        end else begin
                            idx  <= idx + 1'b1;
                            go_q <= 1'b1;
                            tx_q <= CMD_FILL;
                        end
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    assign csn_o      = csn_q;
    assign sd_oe_o    = oe_q;
    assign done_o     = done_q;
    assign detected_o = res_q.present;
    assign size_o     = res_q.bytes;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(start_i)) |-> ($stable(detected_o) && $stable(size_o)));

    // R6
    absent_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !detected_o |-> (size_o == '0));

    // R5
    idle_sck_chk: assert property (@(posedge clk) disable iff (rst)
        csn_o |-> !sck_o);

    // R4
    oe_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (sd_oe_o != 4'h0) |-> !csn_o);

    // R2
    busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(csn_o) && sd_oe_o == 4'hF) |-> !$past(busy_i));

endmodule

// File: tb/psram_probe_seq_test.sv
module psram_probe_seq_test;
    localparam int DIV = 30;
    localparam int GAP = 30;

    typedef struct packed {
        logic [7:0]  fill;
        logic [7:0]  die;
        logic [7:0]  eid;
        logic        det;
        logic [23:0] sz;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 8'h5D, 8'h00, 1'b1, 24'h200000},
        '{8'h3C, 8'h5D, 8'h26, 1'b1, 24'h800000},
        '{8'h00, 8'h5D, 8'h40, 1'b1, 24'h800000},
        '{8'hFF, 8'h5D, 8'h20, 1'b1, 24'h400000},
        '{8'h12, 8'h5D, 8'h3F, 1'b1, 24'h400000},
        '{8'h5D, 8'h5D, 8'h60, 1'b1, 24'h100000},
        '{8'h81, 8'h5D, 8'hE0, 1'b1, 24'h100000},
        '{8'h5D, 8'h5C, 8'h40, 1'b0, 24'h000000},
        '{8'h5D, 8'h00, 8'h00, 1'b0, 24'h000000},
        '{8'h77, 8'h5D, 8'h5F, 1'b1, 24'h800000},
        '{8'h5D, 8'h5D, 8'hA0, 1'b1, 24'h100000},
        '{8'h5D, 8'hFF, 8'h26, 1'b0, 24'h000000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        busy_i = 1'b0;
    logic        sck_o;
    logic        csn_o;
    logic [3:0]  sd_o;
    logic [3:0]  sd_oe_o;
    logic [3:0]  sd_i;
    logic        done_o;
    logic        detected_o;
    logic [23:0] size_o;

    int checks = 0;
    int errs = 0;
    int cyc = 0;

    logic [55:0] stream = '0;
    logic        clr = 1'b0;
    logic        sck_prev = 1'b0;
    logic        csn_prev = 1'b1;
    logic [3:0]  sd_prev = '0;
    logic [7:0]  qbyte = '0;
    int          qrise_cnt = 0;
    int          qrise0 = 0;
    int          qrise1 = 0;
    logic [55:0] idbits = '0;
    int          idcnt = 0;
    int          mbit = 0;
    int          rise_cyc = 0;
    int          gapval = 0;
    int          m0err = 0;

    always #5 clk = ~clk;

    psram_probe_seq #(.DIV(DIV), .GAP_CYCLES(GAP)) uut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .busy_i     (busy_i),
        .sck_o      (sck_o),
        .csn_o      (csn_o),
        .sd_o       (sd_o),
        .sd_oe_o    (sd_oe_o),
        .sd_i       (sd_i),
        .done_o     (done_o),
        .detected_o (detected_o),
        .size_o     (size_o)
    );

    assign sd_i = {2'b00, (mbit < 56) ? stream[55 - mbit] : 1'b0, 1'b0};

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: observes pins mid-cycle, away from the active edge.
    always @(negedge clk) begin
        sck_prev <= sck_o;
        csn_prev <= csn_o;
        sd_prev  <= sd_o;
        if (clr) begin
            qbyte <= '0; qrise_cnt <= 0; idbits <= '0; idcnt <= 0;
            mbit <= 0; gapval <= 0;
        end else begin
            if (sck_o && !sck_prev) begin
                if (sd_o != sd_prev) m0err <= m0err + 1;
                if (sd_oe_o == 4'hF) begin
                    qbyte <= {qbyte[3:0], sd_o};
                    if (qrise_cnt == 0) qrise0 <= cyc;
                    if (qrise_cnt == 1) qrise1 <= cyc;
                    qrise_cnt <= qrise_cnt + 1;
                end else if (sd_oe_o == 4'h1) begin
                    idbits <= {idbits[54:0], sd_o[0]};
                    idcnt  <= idcnt + 1;
                end
            end
            if (!sck_o && sck_prev && sd_oe_o == 4'h1) mbit <= mbit + 1;
            if (csn_o && !csn_prev) rise_cyc <= cyc;
            if (!csn_o && csn_prev && sd_oe_o == 4'h1) gapval <= cyc - rise_cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic prepare(input vec_t v);
        stream = {v.fill, v.fill, v.fill, v.fill, v.fill, v.die, v.eid};
        @(posedge clk); clr = 1'b1;
        @(posedge clk); clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic finish_probe(input vec_t v);
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done_o == 1'b1, "R9", "done reached", 64'(done_o), 64'd1);
        check(csn_o == 1'b1, "R9", "csn high at done", 64'(csn_o), 64'd1);
        check(detected_o == v.det, "R6", "detected", 64'(detected_o), 64'(v.det));
        check(size_o == v.sz, "R7", "size", 64'(size_o), 64'(v.sz));
        check(qbyte == 8'hF5 && qrise_cnt == 2, "R3", "quad byte",
              64'(qbyte), 64'hF5);
        check(gapval == GAP, "R3", "deselect gap", 64'(gapval), 64'(GAP));
        check(qrise1 - qrise0 == DIV, "R8", "sck period",
              64'(qrise1 - qrise0), 64'(DIV));
        check(idbits == {8'h9F, {6{8'hFF}}} && idcnt == 56, "R4", "id frame bits",
              64'(idbits), 64'h9FFFFFFFFFFFFF);
        @(negedge clk);
        check(done_o == 1'b0, "R9", "done one cycle", 64'(done_o), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        check(csn_o == 1'b1 && sck_o == 1'b0 && sd_oe_o == 4'h0, "R1", "pins in reset",
              64'({csn_o, sck_o, sd_oe_o}), 64'h20);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0 && detected_o == 1'b0 && size_o == '0, "R1", "outputs after reset",
              64'({done_o, detected_o, size_o}), 64'd0);

        // Table walk: R3 R4 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            prepare(VECS[i]);
            pulse_start();
            finish_probe(VECS[i]);
        end

        // R9: result holds after done
        prepare(VECS[0]);
        pulse_start();
        finish_probe(VECS[0]);
        repeat (200) @(negedge clk);
        check(detected_o == 1'b1 && size_o == 24'h200000, "R9", "result held",
              64'(size_o), 64'h200000);

        // R2: busy blocks the probe; R9: request clears the result
        prepare(VECS[3]);
        busy_i = 1'b1;
        pulse_start();
        repeat (300) @(negedge clk);
        check(csn_o == 1'b1, "R2", "csn held while busy", 64'(csn_o), 64'd1);
        check(detected_o == 1'b0 && size_o == '0, "R9", "request clears result",
              64'(size_o), 64'd0);
        busy_i = 1'b0;
        finish_probe(VECS[3]);

        // R10: second request during a probe is ignored
        prepare(VECS[1]);
        pulse_start();
        repeat (500) @(negedge clk);
        pulse_start();
        finish_probe(VECS[1]);
        begin
            int lows = 0;
            repeat (3000) begin
                @(negedge clk);
                if (!csn_o) lows++;
            end
            check(lows == 0, "R10", "no second probe", 64'(lows), 64'd0);
        end

        // R5: data never changed at a rising serial clock
        check(m0err == 0, "R5", "mode 0 data timing", 64'(m0err), 64'd0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule